// File: doc/BRIEF.md
# Sync Frame Code-Group Sequencer

This block chooses the two octets that make up each link frame of a serial sample stream, together with a control-character flag for each octet, and hands them to a downstream 8B/10B encoder. It acts only on frame boundaries, which are marked by a one-cycle `frame_tick` strobe.

At each strobe the block samples the sync request. With no request pending, the frame carries the two sample octets unchanged. With a request pending, the first code group is the K28.5 comma.

The second code group of a sync frame depends on two inputs. If the initial-synchronization mode is off, the second code group is another K28.5. If the mode is on, the second code group depends on the encoder's running disparity. When the disparity is positive, the block sends D5.6, which brings the disparity back to negative. When the disparity is negative, the block sends D16.2, which keeps it negative. Sync frames repeat on every strobe for as long as the request stays high.

Top module: `sync_frame_seq`

## Requirements
- R1: A synchronous active-high `rst` clears both octets and both K flags to 0 and drives `frame_valid` and `sync_active` low from the next cycle on.
- R2: `frame_valid` is high in exactly the cycles that follow a cycle in which `frame_tick` was high at the clock edge.
- R3: A strobe with `sync_req` low loads `cg1_octet` = `sample_in[15:8]` and `cg2_octet` = `sample_in[7:0]`, with both K flags at 0.
- R4: A strobe with `sync_req` high loads `cg1_octet` = 0xBC (K28.5) with `cg1_is_k` = 1.
- R5: A strobe with `sync_req` high and `init_mode` low loads `cg2_octet` = 0xBC with `cg2_is_k` = 1, whatever the value of `rd_pos`.
- R6: A strobe with `sync_req`, `init_mode` and `rd_pos` all high (`rd_pos` = 1 means positive disparity) loads `cg2_octet` = 0xC5 (D5.6) with `cg2_is_k` = 0.
- R7: A strobe with `sync_req` and `init_mode` high and `rd_pos` low (negative disparity) loads `cg2_octet` = 0x50 (D16.2) with `cg2_is_k` = 0.
- R8: `sync_active` takes the value of `sync_req` at each strobe, so sync frames follow one another on consecutive strobes while the request stays high.
- R9: In cycles without a strobe, changes on `sync_req`, `init_mode`, `rd_pos` and `sample_in` are ignored, and all octet, flag and `sync_active` outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | Frame boundary strobe, one cycle wide |
| sync_req | input | 1 | Sync request, sampled at the strobe |
| init_mode | input | 1 | Initial-synchronization mode enable |
| rd_pos | input | 1 | Encoder running disparity, 1 = positive |
| sample_in | input | 16 | Sample octets, high byte goes to code group 1 |
| cg1_octet | output | 8 | Octet for code group 1 |
| cg1_is_k | output | 1 | Code group 1 is a control character |
| cg2_octet | output | 8 | Octet for code group 2 |
| cg2_is_k | output | 1 | Code group 2 is a control character |
| frame_valid | output | 1 | A new frame was loaded in this cycle |
| sync_active | output | 1 | The current frame is a sync frame |

## Verification
Every result is due one clock after the edge that sampled its strobe, because there is a single register stage between the inputs and the outputs. In cycles without a strobe the outputs must still hold the previous frame. The bench drives its inputs on the falling edge and updates its expected frame only when it applied a strobe. It then compares all outputs 1 ns after the next rising edge, so each comparison sees exactly one register update. Random strobes, requests, modes, disparities and data are mixed with directed cases: back-to-back sync frames, both disparities with the mode on and off, and a reset in the middle of the run.

// File: rtl/sync_frame_pkg.sv
package sync_frame_pkg;
  localparam int OCT_W   = 8;
  localparam int GROUPS  = 2;
  localparam int FRAME_W = OCT_W * GROUPS;

  localparam logic [OCT_W-1:0] OCT_K28_5 = 8'hBC;
  localparam logic [OCT_W-1:0] OCT_D5_6  = 8'hC5;
  localparam logic [OCT_W-1:0] OCT_D16_2 = 8'h50;

  typedef enum logic [1:0] {
    FK_DATA      = 2'd0,
    FK_TWO_COMMA = 2'd1,
    FK_FIX_POS   = 2'd2,
    FK_KEEP_NEG  = 2'd3
  } frame_kind_t;

  typedef struct packed {
    logic             is_k;
    logic [OCT_W-1:0] oct;
  } cgroup_t;

  function automatic frame_kind_t pick_kind(input logic req, input logic mode,
                                            input logic rd_p);
    if (!req)      return FK_DATA;
    else if (!mode) return FK_TWO_COMMA;
    else if (rd_p)  return FK_FIX_POS;
    else            return FK_KEEP_NEG;
  endfunction

  function automatic cgroup_t group_for(input frame_kind_t kind, input int idx,
                                        input logic [OCT_W-1:0] data_oct);
    cgroup_t g;
    g = '{is_k: 1'b0, oct: data_oct};
    if (kind != FK_DATA) begin
      if (idx == 0) g = '{is_k: 1'b1, oct: OCT_K28_5};
      else begin
        unique case (kind)
          FK_TWO_COMMA: g = '{is_k: 1'b1, oct: OCT_K28_5};
          FK_FIX_POS:   g = '{is_k: 1'b0, oct: OCT_D5_6};
          default:      g = '{is_k: 1'b0, oct: OCT_D16_2};
        endcase
      end
    end
    return g;
  endfunction
endpackage

// File: rtl/sfs_decide.sv
module sfs_decide
  import sync_frame_pkg::*;
(
  input  logic        sync_req,
  input  logic        init_mode,
  input  logic        rd_pos,
  output frame_kind_t kind
);
  always_comb kind = pick_kind(sync_req, init_mode, rd_pos);
endmodule

// File: rtl/sfs_cg_build.sv
module sfs_cg_build
  import sync_frame_pkg::*;
(
  input  frame_kind_t        kind,
  input  logic [FRAME_W-1:0] sample_in,
  output cgroup_t            grp [GROUPS]
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int HI = FRAME_W - 1 - g * OCT_W;
    always_comb grp[g] = group_for(kind, g, sample_in[HI -: OCT_W]);
  end
endmodule

// File: rtl/sync_frame_seq.sv
module sync_frame_seq
  import sync_frame_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_tick,
  input  logic               sync_req,
  input  logic               init_mode,
  input  logic               rd_pos,
  input  logic [FRAME_W-1:0] sample_in,
  output logic [OCT_W-1:0]   cg1_octet,
  output logic               cg1_is_k,
  output logic [OCT_W-1:0]   cg2_octet,
  output logic               cg2_is_k,
  output logic               frame_valid,
  output logic               sync_active
);
  frame_kind_t kind;
  cgroup_t     grp_next [GROUPS];
  cgroup_t     grp_q    [GROUPS];
  logic        take_frame;
  logic        sync_q;
  logic        valid_q;

  assign take_frame = frame_tick;

  sfs_decide u_decide (
    .sync_req (sync_req),
    .init_mode(init_mode),
    .rd_pos   (rd_pos),
    .kind     (kind)
  );

  sfs_cg_build u_build (
    .kind     (kind),
    .sample_in(sample_in),
    .grp      (grp_next)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)             grp_q[g] <= '0;
      else if (take_frame) grp_q[g] <= grp_next[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take_frame;
      if (take_frame) sync_q <= (kind != FK_DATA);
    end
  end

  assign cg1_octet   = grp_q[0].oct;
  assign cg1_is_k    = grp_q[0].is_k;
  assign cg2_octet   = grp_q[1].oct;
  assign cg2_is_k    = grp_q[1].is_k;
  assign frame_valid = valid_q;
  assign sync_active = sync_q;
endmodule

// File: rtl/sync_frame_seq_chk.sv
module sync_frame_seq_chk
  import sync_frame_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               frame_tick,
  input logic               sync_req,
  input logic               init_mode,
  input logic               rd_pos,
  input logic [FRAME_W-1:0] sample_in,
  input logic [OCT_W-1:0]   cg1_octet,
  input logic               cg1_is_k,
  input logic [OCT_W-1:0]   cg2_octet,
  input logic               cg2_is_k,
  input logic               frame_valid,
  input logic               sync_active,
  input logic               take_frame
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (cg1_octet == '0 && cg2_octet == '0 && !cg1_is_k && !cg2_is_k
             && !frame_valid && !sync_active));
  // R2
  valid_tick_chk: assert property (@(posedge clk) disable iff (rst)
    take_frame |=> frame_valid);
  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !take_frame |=> !frame_valid);
  // R3
  data_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (take_frame && !sync_req) |=> (cg1_octet == $past(sample_in[FRAME_W-1 -: OCT_W])
      && cg2_octet == $past(sample_in[OCT_W-1:0]) && !cg1_is_k && !cg2_is_k));
  // R4
  comma_first_chk: assert property (@(posedge clk) disable iff (rst)
    (take_frame && sync_req) |=> (cg1_octet == 8'hBC && cg1_is_k));
  // R5
  comma_second_chk: assert property (@(posedge clk) disable iff (rst)
    (take_frame && sync_req && !init_mode) |=> (cg2_octet == 8'hBC && cg2_is_k));
  // R6
  fix_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (take_frame && sync_req && init_mode && rd_pos) |=> (cg2_octet == 8'hC5 && !cg2_is_k));
  // R7
  keep_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (take_frame && sync_req && init_mode && !rd_pos) |=> (cg2_octet == 8'h50 && !cg2_is_k));
  // R8
  sync_flag_chk: assert property (@(posedge clk) disable iff (rst)
    take_frame |=> (sync_active == $past(sync_req)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take_frame |=> ($stable(cg1_octet) && $stable(cg2_octet) && $stable(cg1_is_k)
                     && $stable(cg2_is_k) && $stable(sync_active)));
endmodule

bind sync_frame_seq sync_frame_seq_chk u_chk (.*);

// File: tb/tb_sync_frame_seq.sv
module tb_sync_frame_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_tick = 1'b0;
  logic        sync_req = 1'b0;
  logic        init_mode = 1'b0;
  logic        rd_pos = 1'b0;
  logic [15:0] sample_in = '0;
  logic [7:0]  cg1_octet, cg2_octet;
  logic        cg1_is_k, cg2_is_k, frame_valid, sync_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] e_o1, e_o2;
  logic       e_k1, e_k2, e_v, e_s;

  always #2.5 clk = ~clk;

  sync_frame_seq dut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .sync_req(sync_req),
    .init_mode(init_mode), .rd_pos(rd_pos), .sample_in(sample_in),
    .cg1_octet(cg1_octet), .cg1_is_k(cg1_is_k), .cg2_octet(cg2_octet),
    .cg2_is_k(cg2_is_k), .frame_valid(frame_valid), .sync_active(sync_active)
  );

  // Bench restatement: second group as {flag, octet}
  function automatic logic [8:0] want_g2(input logic rq, input logic md,
                                         input logic rd, input logic [7:0] lo);
    if (!rq) return {1'b0, lo};
    if (!md) return {1'b1, 8'hBC};
    return rd ? {1'b0, 8'hC5} : {1'b0, 8'h50};
  endfunction

  function automatic logic [8:0] want_g1(input logic rq, input logic [7:0] hi);
    return rq ? {1'b1, 8'hBC} : {1'b0, hi};
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_for(input logic tk, input logic rq, input logic md,
                                    input logic rd, input logic r);
    if (r)   return "R1 reset";
    if (!tk) return "R9 hold";
    if (!rq) return "R3 data";
    if (!md) return "R5 comma pair";
    return rd ? "R6 D5.6" : "R7 D16.2";
  endfunction

  task automatic step(input logic r, input logic tk, input logic rq, input logic md,
                      input logic rd, input logic [15:0] d);
    string tg;
    @(negedge clk);
    rst = r; frame_tick = tk; sync_req = rq; init_mode = md; rd_pos = rd; sample_in = d;
    if (r) begin
      e_o1 = '0; e_o2 = '0; e_k1 = 0; e_k2 = 0; e_v = 0; e_s = 0;
    end else begin
      e_v = tk;
      if (tk) begin
        {e_k1, e_o1} = want_g1(rq, d[15:8]);
        {e_k2, e_o2} = want_g2(rq, md, rd, d[7:0]);
        e_s = rq;
      end
    end
    tg = tag_for(tk, rq, md, rd, r);
    @(posedge clk);
    #1;
    cmp({tg, " R4 cg1"}, {23'd0, cg1_is_k, cg1_octet}, {23'd0, e_k1, e_o1});
    cmp({tg, " cg2"}, {23'd0, cg2_is_k, cg2_octet}, {23'd0, e_k2, e_o2});
    cmp("R2 frame_valid", {31'd0, frame_valid}, {31'd0, e_v});
    cmp("R8 sync_active", {31'd0, sync_active}, {31'd0, e_s});
  endtask

  initial begin
    void'($urandom(32'd1234));
    step(1, 0, 0, 0, 0, 16'h0000);
    step(1, 1, 1, 1, 1, 16'hFFFF);   // R1 strobe ignored in reset
    step(0, 1, 0, 0, 0, 16'hA55A);   // R3
    step(0, 1, 1, 0, 1, 16'h1234);   // R4 R5
    step(0, 1, 1, 0, 0, 16'h1234);   // R5 disparity ignored
    step(0, 1, 1, 1, 1, 16'h0000);   // R6
    step(0, 1, 1, 1, 0, 16'h0000);   // R7
    step(0, 1, 1, 1, 0, 16'h0000);   // R8 back to back
    step(0, 0, 0, 0, 1, 16'hBEEF);   // R9 changes ignored
    step(0, 0, 1, 1, 0, 16'hCAFE);   // R9
    step(0, 1, 0, 1, 1, 16'h5C5C);   // R3 mode ignored
    for (int i = 0; i < 4000; i++) begin
      logic r;
      r = (i == 2000);
      step(r, ($urandom % 3) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
           16'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule